// File: doc/BRIEF.md
# Codec Serial Port with Half-Frame Control Slot

This block is the slave side of a synchronous serial link to an external audio codec. The codec owns the bit clock and the frame-sync line. The port oversamples both lines on its own system clock. It sends one 16-bit data word after each frame sync and captures the 16-bit word that the codec returns in the same slot. A frame is 128 bit clocks long.

Software may queue a control word at any time. The port then asks for a control exchange by setting the least significant bit of its next outgoing data word to 1. Without a queued word that bit is always sent as 0. A codec that sees the request raises a second sync pulse 64 bit clocks after the normal one. On that pulse the port sends the queued control word and stores the word it receives in a control-read register, which is kept apart from the normal receive path. Any sync pulse at a position the port does not expect is dropped and reported on a one-cycle error strobe.

Top module: `codec_slot_port`

## Requirements
- R1: Reset sets `sdo`, `ctl_pend`, `rx_word`, `ctl_rdata`, `rx_valid`, `ctl_done` and `sync_err` to 0, drops any queued control word and clears frame lock.
- R2: On each accepted normal sync, the port sends `tx_word` MSB first on `sdo`. Bit 15 is valid for the bit clock that follows the sync, and one bit is sent per bit clock. When no control word is queued, bit 0 of the sent word is 0 whatever `tx_word[0]` holds.
- R3: A `ctl_wr` pulse stores `ctl_wdata` and raises `ctl_pend` on the next clock. The next normal word then carries 1 in bit 0. A write in the same clock as the normal sync still counts.
- R4: When a request was sent, a sync sampled 64 bit clocks after the normal sync starts the control slot. The port sends the queued control word there, MSB first, starting on the next bit clock.
- R5: The 16 bits sampled on `sdi` after a normal sync appear on `rx_word`, MSB first, together with a one-cycle `rx_valid`. A control slot leaves `rx_word` unchanged.
- R6: The 16 bits sampled after the secondary sync appear on `ctl_rdata` with a one-cycle `ctl_done`. `ctl_pend` then drops unless a newer write arrived.
- R7: A sync at any other position while locked, including a position-64 sync when no request was sent, is ignored. It raises `sync_err` for one clock and leaves `rx_word`, `ctl_rdata` and `ctl_done` untouched.
- R8: A write that arrives after the control slot has been loaded, including one in the same clock as `ctl_done`, stays queued. `ctl_pend` stays 1 and the next frame requests again with the newest word.
- R9: If no sync is sampled 128 bit clocks after the last normal sync, `sync_err` pulses and lock is lost. The next sync is then accepted as a normal sync.
- R10: `sdo` is 0 on every bit clock outside the 16 bits of an active slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Bit clock from the codec |
| fsync_in | input | 1 | Frame sync from the codec, one bit clock wide, active high |
| sdi | input | 1 | Serial data from the codec, sampled on bit-clock rising edges |
| sdo | output | 1 | Serial data to the codec, changed on bit-clock falling edges |
| tx_word | input | 16 | Normal data word, sampled at each normal sync |
| ctl_wr | input | 1 | Queue strobe for a control word |
| ctl_wdata | input | 16 | Control word to queue |
| rx_word | output | 16 | Last normal word received |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` updates |
| ctl_rdata | output | 16 | Last control word received |
| ctl_done | output | 1 | One-cycle strobe when a control exchange completes |
| ctl_pend | output | 1 | A control word is queued or being exchanged |
| sync_err | output | 1 | One-cycle strobe for an unexpected or missing sync |

## Verification
Two events can fall in the same system clock: a software write to the control queue, and the control exchange either being loaded or completing. The bench holds `ctl_wr` high for several bit clocks around the end of a control slot, so one of the writes lands in the completion clock. It then checks three things: `ctl_pend` stays high, the next normal word carries the request bit, and the following control slot carries the newer word rather than the one already sent. Codec-side checks cover the other features: misplaced, unrequested and missing sync pulses.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;
  // which kind of slot the shifter is currently serving
  typedef enum logic {
    SLOT_NORM = 1'b0,
    SLOT_CTRL = 1'b1
  } slot_kind_e;
endpackage

// File: rtl/codec_edge_sync.sv
module codec_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_raw,
  input  logic fs_raw,
  input  logic sd_raw,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic fs_s,
  output logic sd_s
);
  // bit 0 clock, bit 1 sync, bit 2 data: all three share one delay
  logic [2:0] pipe [SYNC_STAGES];
  logic       bclk_prev;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= {sd_raw, fs_raw, bclk_raw};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bclk_prev <= 1'b0;
    else     bclk_prev <= pipe[SYNC_STAGES-1][0];
  end

  assign bclk_rise = pipe[SYNC_STAGES-1][0] & ~bclk_prev;
  assign bclk_fall = ~pipe[SYNC_STAGES-1][0] & bclk_prev;
  assign fs_s      = pipe[SYNC_STAGES-1][1];
  assign sd_s      = pipe[SYNC_STAGES-1][2];
endmodule

// File: rtl/codec_slot_shifter.sv
module codec_slot_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise,
  input  logic         fall,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         sd_in,
  output logic         sd_out,
  output logic         done,
  output logic [W-1:0] rx_out
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

  logic             busy;
  logic [W-1:0]     tx_sh;
  logic [W-1:0]     rx_sh;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      cnt    <= '0;
      sd_out <= 1'b0;
      done   <= 1'b0;
      rx_out <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        tx_sh <= load_word;
        cnt   <= '0;
      end else if (rise && busy) begin
        rx_sh <= {rx_sh[W-2:0], sd_in};
        cnt   <= cnt + 1'b1;
        if (cnt == LAST_BIT) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          rx_out <= {rx_sh[W-2:0], sd_in};
        end
      end
      // falls never coincide with a load (load happens on a rise)
      if (fall) begin
        if (busy) begin
          sd_out <= tx_sh[W-1];
          tx_sh  <= {tx_sh[W-2:0], 1'b0};
        end else begin
          sd_out <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/codec_slot_port.sv
module codec_slot_port
  import codec_slot_pkg::*;
#(
  parameter int W           = 16,
  parameter int FRAME_LEN   = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bclk_in,
  input  logic         fsync_in,
  input  logic         sdi,
  output logic         sdo,
  input  logic [W-1:0] tx_word,
  input  logic         ctl_wr,
  input  logic [W-1:0] ctl_wdata,
  output logic [W-1:0] rx_word,
  output logic         rx_valid,
  output logic [W-1:0] ctl_rdata,
  output logic         ctl_done,
  output logic         ctl_pend,
  output logic         sync_err
);
  localparam int POS_W = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] HALF_POS = POS_W'(FRAME_LEN / 2 - 1);

  logic rise, fall, fs_s, sd_s;

  codec_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .bclk_raw  (bclk_in),
    .fs_raw    (fsync_in),
    .sd_raw    (sdi),
    .bclk_rise (rise),
    .bclk_fall (fall),
    .fs_s      (fs_s),
    .sd_s      (sd_s)
  );

  logic             locked;
  logic             req_sent;
  logic             pend_q;
  logic             active;
  logic [POS_W-1:0] pos;
  logic [W-1:0]     ctl_q;
  slot_kind_e       kind;

  logic         exp_norm, exp_sec, req;
  logic         ld;
  logic [W-1:0] ld_word;
  logic         sh_done;
  logic [W-1:0] sh_rx;

  assign exp_norm = !locked || (pos == LAST_POS);
  assign exp_sec  = locked && (pos == HALF_POS) && req_sent;
  assign req      = pend_q | ctl_wr;

  always_comb begin
    ld      = 1'b0;
    ld_word = '0;
    if (rise && fs_s) begin
      if (exp_norm) begin
        ld      = 1'b1;
        ld_word = {tx_word[W-1:1], req};
      end else if (exp_sec) begin
        ld      = 1'b1;
        ld_word = ctl_q;
      end
    end
  end

  codec_slot_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise),
    .fall      (fall),
    .load      (ld),
    .load_word (ld_word),
    .sd_in     (sd_s),
    .sd_out    (sdo),
    .done      (sh_done),
    .rx_out    (sh_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      locked    <= 1'b0;
      req_sent  <= 1'b0;
      pend_q    <= 1'b0;
      active    <= 1'b0;
      pos       <= '0;
      ctl_q     <= '0;
      kind      <= SLOT_NORM;
      rx_word   <= '0;
      rx_valid  <= 1'b0;
      ctl_rdata <= '0;
      ctl_done  <= 1'b0;
      sync_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      ctl_done <= 1'b0;
      sync_err <= 1'b0;
      if (ctl_wr) begin
        ctl_q  <= ctl_wdata;
        pend_q <= 1'b1;
      end
      if (rise) begin
        if (fs_s && exp_norm) begin
          pos      <= '0;
          locked   <= 1'b1;
          req_sent <= req;
          kind     <= SLOT_NORM;
        end else if (fs_s && exp_sec) begin
          pos      <= pos + 1'b1;
          req_sent <= 1'b0;
          kind     <= SLOT_CTRL;
          active   <= 1'b1;
          pend_q   <= ctl_wr;   // queued word consumed; a same-cycle write stays queued
        end else if (locked && pos == LAST_POS) begin
          sync_err <= 1'b1;     // expected sync missing
          locked   <= 1'b0;
          pos      <= '0;
        end else begin
          if (fs_s)   sync_err <= 1'b1;
          if (locked) pos <= pos + 1'b1;
        end
      end
      if (sh_done) begin
        if (kind == SLOT_CTRL) begin
          ctl_rdata <= sh_rx;
          ctl_done  <= 1'b1;
          active    <= 1'b0;
        end else begin
          rx_word  <= sh_rx;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  assign ctl_pend = pend_q | active;
endmodule

// File: rtl/codec_slot_port_chk.sv
module codec_slot_port_chk (
  input logic clk,
  input logic rst,
  input logic sdo,
  input logic ctl_wr,
  input logic rx_valid,
  input logic ctl_done,
  input logic ctl_pend,
  input logic sync_err
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!ctl_pend && !sdo && !sync_err && !ctl_done && !rx_valid));

  // R3
  a_r3_write_pends: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> ctl_pend);

  // R6
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    ctl_done |=> !ctl_done);

  // R6
  a_r6_done_had_pend: assert property (@(posedge clk) disable iff (rst)
    ctl_done |-> $past(ctl_pend));

  // R7
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
    sync_err |=> !sync_err);

  // R5
  a_r5_paths_apart: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && ctl_done));
endmodule

bind codec_slot_port codec_slot_port_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sdo      (sdo),
  .ctl_wr   (ctl_wr),
  .rx_valid (rx_valid),
  .ctl_done (ctl_done),
  .ctl_pend (ctl_pend),
  .sync_err (sync_err)
);

// File: tb/codec_slot_port_bench.sv
module codec_slot_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_in = 1'b0;
  logic        fsync_in = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [15:0] tx_word = '0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] rx_word;
  logic        rx_valid;
  logic [15:0] ctl_rdata;
  logic        ctl_done;
  logic        ctl_pend;
  logic        sync_err;

  always #4 clk = ~clk;

  codec_slot_port u_codec_slot_port (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .fsync_in(fsync_in), .sdi(sdi),
    .sdo(sdo), .tx_word(tx_word), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .rx_word(rx_word), .rx_valid(rx_valid), .ctl_rdata(ctl_rdata),
    .ctl_done(ctl_done), .ctl_pend(ctl_pend), .sync_err(sync_err)
  );

  int n_chk = 0;
  int n_err = 0;
  int err_cnt = 0;
  int done_cnt = 0;
  int valid_cnt = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    if (!rst) begin
      if (sync_err) err_cnt++;
      if (ctl_done) done_cnt++;
      if (rx_valid) valid_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one frame of 128 bit clocks, 12 system clocks each, seen from the codec
  task automatic run_frame(input logic [15:0] cn, input logic [15:0] cc,
                           input bit send_norm, input bit force_sec,
                           input int extra_k, input bit hold,
                           input logic [15:0] hold_data,
                           output logic [15:0] got_n, output logic [15:0] got_c,
                           output bit sec, output int idle_bad);
    got_n = '0; got_c = '0; sec = 1'b0; idle_bad = 0;
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      if (k == 64) sec = force_sec || got_n[0];
      bclk_in  = 1'b0;
      fsync_in = (k == 0 && send_norm) || (k == 64 && sec) || (k == extra_k);
      if (k >= 1 && k <= 16)            sdi = cn[16-k];
      else if (sec && k >= 65 && k <= 80) sdi = cc[80-k];
      else                              sdi = 1'b0;
      ctl_wr    = hold && k >= 79 && k <= 81;
      ctl_wdata = hold_data;
      repeat (5) @(negedge clk);
      bclk_in = 1'b1;
      if (k >= 1 && k <= 16)              got_n[16-k] = sdo;
      else if (sec && k >= 65 && k <= 80) got_c[80-k] = sdo;
      else if (sdo)                       idle_bad++;
      repeat (6) @(negedge clk);
    end
    ctl_wr = 1'b0;
  endtask

  task automatic ctl_write(input logic [15:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  typedef struct packed {
    logic [15:0] tx;
    logic [15:0] cn;
    logic        wr;
    logic [15:0] cw;
    logic [15:0] cc;
    logic        hold;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'hA5A5, 16'h1234, 1'b0, 16'h0000, 16'h0000, 1'b0},
    '{16'h0F0E, 16'hBEEF, 1'b1, 16'hC3C3, 16'h5A5A, 1'b0},
    '{16'hFFFF, 16'h0001, 1'b0, 16'h0000, 16'h0000, 1'b0},
    '{16'h8000, 16'h7FFF, 1'b1, 16'h0001, 16'h8000, 1'b1},
    '{16'h1111, 16'h2222, 1'b0, 16'h0000, 16'h3333, 1'b0},
    '{16'h0000, 16'hFFFF, 1'b0, 16'h0000, 16'h0000, 1'b0}
  };

  initial begin
    logic [15:0] gn, gc, exp_n, held;
    bit          sec, m_pend;
    logic [15:0] m_word;
    int          idle, e0, d0, v0;
    m_pend = 1'b0; m_word = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(sdo == 1'b0 && ctl_pend == 1'b0 && sync_err == 1'b0, "R1 reset outputs",
        {sdo, ctl_pend, sync_err}, 0);
    chk(rx_word == 16'h0 && ctl_rdata == 16'h0, "R1 reset words",
        {rx_word, ctl_rdata}, 0);

    for (int i = 0; i < 6; i++) begin
      if (VECS[i].wr) begin
        ctl_write(VECS[i].cw);
        m_pend = 1'b1; m_word = VECS[i].cw;
      end
      tx_word = VECS[i].tx;
      exp_n = {VECS[i].tx[15:1], m_pend};
      e0 = err_cnt; d0 = done_cnt; v0 = valid_cnt;
      run_frame(VECS[i].cn, VECS[i].cc, 1'b1, 1'b0, -1, VECS[i].hold,
                ~VECS[i].cw, gn, gc, sec, idle);
      chk(gn == exp_n, m_pend ? "R3 request bit in word" : "R2 normal word", gn, exp_n);
      chk(rx_word == VECS[i].cn && valid_cnt == v0 + 1, "R5 normal receive",
          rx_word, VECS[i].cn);
      chk(idle == 0, "R10 sdo idle low", idle, 0);
      chk(err_cnt == e0, "R7 no spurious error", err_cnt - e0, 0);
      if (m_pend) begin
        chk(gc == m_word, "R4 control word sent", gc, m_word);
        chk(ctl_rdata == VECS[i].cc && done_cnt == d0 + 1, "R6 control receive",
            ctl_rdata, VECS[i].cc);
        if (VECS[i].hold) begin
          m_pend = 1'b1; m_word = ~VECS[i].cw;
        end else begin
          m_pend = 1'b0;
        end
      end
      chk(ctl_pend == m_pend, VECS[i].hold ? "R8 write at completion kept" : "R6 pending state",
          ctl_pend, m_pend);
    end

    // R7: misplaced sync at bit clock 30 is ignored
    tx_word = 16'h1234; e0 = err_cnt;
    run_frame(16'h4321, 16'h0, 1'b1, 1'b0, 30, 1'b0, 16'h0, gn, gc, sec, idle);
    chk(err_cnt == e0 + 1, "R7 misplaced sync flagged", err_cnt - e0, 1);
    chk(rx_word == 16'h4321 && gn == 16'h1234, "R7 misplaced sync ignored", rx_word, 16'h4321);

    // R7: secondary sync without a request is ignored
    held = ctl_rdata; e0 = err_cnt; d0 = done_cnt;
    run_frame(16'h0F0F, 16'hDEAD, 1'b1, 1'b1, -1, 1'b0, 16'h0, gn, gc, sec, idle);
    chk(err_cnt == e0 + 1, "R7 unrequested secondary flagged", err_cnt - e0, 1);
    chk(ctl_rdata == held && done_cnt == d0, "R7 unrequested secondary ignored",
        ctl_rdata, held);

    // R9: missing normal sync, then relock
    e0 = err_cnt;
    run_frame(16'h0, 16'h0, 1'b0, 1'b0, -1, 1'b0, 16'h0, gn, gc, sec, idle);
    chk(err_cnt == e0 + 1, "R9 missing sync flagged", err_cnt - e0, 1);
    tx_word = 16'hC0DE; e0 = err_cnt;
    run_frame(16'h5555, 16'h0, 1'b1, 1'b0, -1, 1'b0, 16'h0, gn, gc, sec, idle);
    chk(gn == 16'hC0DE && rx_word == 16'h5555 && err_cnt == e0, "R9 relock on next sync",
        gn, 16'hC0DE);

    // R1: reset drops a queued control word
    ctl_write(16'h7777);
    chk(ctl_pend == 1'b1, "R3 write raises pending", ctl_pend, 1);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(ctl_pend == 1'b0 && sdo == 1'b0 && rx_word == 16'h0 && ctl_rdata == 16'h0,
        "R1 reset mid-run", {ctl_pend, sdo, rx_word, ctl_rdata}, 0);
    tx_word = 16'h0003;
    run_frame(16'hAAAA, 16'h0, 1'b1, 1'b0, -1, 1'b0, 16'h0, gn, gc, sec, idle);
    chk(gn == 16'h0002 && !sec, "R1 no request after reset", gn, 16'h0002);

    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule